// File: doc/BRIEF.md
# Bi-endian misaligned load unit

This unit sits between a processor load port and a memory that is organised as 32-bit words. A load request gives a byte address, an item size (8, 16 or 32 bits) and a byte-order bit. The unit reads memory and returns the item right-justified and zero-extended in a 32-bit result.

An aligned load, or any 8-bit load, takes one word read. A misaligned 16- or 32-bit load takes two word reads in turn: first the word holding the first byte, then the next word up. The unit then picks the item's bytes out of the pair and places them according to the byte order.

A misaligned load does not fault. It raises a status flag instead, and that flag stays steady for the whole access.

The request side is a valid/ready stream. `req_ready` is high only while the unit is idle. A request is taken on the clock edge at which `req_valid` and `req_ready` are both high, and all request fields are sampled at that edge. Upstream must hold its request while `req_ready` is low.

The result side has no back-pressure. `result` is valid during the single cycle in which `done` is high.

The memory side is a request/ready handshake followed by a read-data strobe. `mem_req` and `mem_addr` stay fixed until `mem_ready` is seen. Exactly one `mem_rvalid` is expected for each accepted read. The unit never has more than one read outstanding.

Top module: `load_align_unit`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `req_ready` is 1, and `mem_req`, `done` and `misaligned` are 0.
- R2: Size encoding on `req_size` is 00 = 8 bits, 01 = 16 bits, 10 (and 11) = 32 bits. A load is misaligned when it is 16 bits at an odd address, or 32 bits at an address that is not a multiple of 4; an 8-bit load is never misaligned. `misaligned` takes this value from the cycle after acceptance and keeps it, unchanged, through the `done` cycle.
- R3: An aligned load, or any 8-bit load, performs exactly one memory read, at word address `req_addr >> 2`.
- R4: A misaligned load performs exactly two memory reads. The first is at word address `req_addr >> 2`. The second is at that word address plus one, wrapping modulo 2^(ADDR_W-2). The second read is requested only after `mem_rvalid` has returned the first word.
- R5: Byte lanes are fixed, whatever the byte order: the byte at address 4k+j is carried in bits [8j+7:8j] of the data read from word k.
- R6: With `req_big_endian` = 0, the byte at the item's lowest address becomes result bits [7:0], and higher addresses fill higher bytes. Bits above the item's size are 0. Example: bytes 11,22,33,44 at increasing addresses load as 32'h44332211.
- R7: With `req_big_endian` = 1, the byte at the item's lowest address becomes the item's most significant byte. Bits above the item's size are 0. Example: the same bytes load as 32'h11223344.
- R8: `done` is high for exactly one cycle per load, with `result` valid in that cycle. `req_ready` is 0 from the cycle after acceptance through the `done` cycle.
- R9: Once raised, `mem_req` and `mem_addr` stay unchanged until the cycle in which `mem_ready` is 1.
- R10: The byte order is taken per request at acceptance. Changing `req_big_endian` during an access has no effect on that access's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the item |
| req_size | input | 2 | Item size code |
| req_big_endian | input | 1 | Byte order for this request |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Loaded item, zero-extended |
| misaligned | output | 1 | Current or last load was misaligned |
| mem_req | output | 1 | Word read request |
| mem_ready | input | 1 | Memory takes the read request |
| mem_addr | output | ADDR_W-2 | Word address of the read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data word |

## Verification
The bench builds the unit with ADDR_W = 6, which gives a 16-word space that the bench models in full. This makes the top-of-memory wrap of the second read reachable: a 32-bit load at byte address 63 must fetch word 15 and then word 0.

All sizes at all four offsets are run in both byte orders. The bench's memory model can also stall `mem_ready` and delay `mem_rvalid`, which exercises the request hold and the wait for the first word before the second read.

// File: rtl/lau_pkg.sv
package lau_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int CNT_W      = OFF_W + 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } state_e;
endpackage

// File: rtl/lau_align_chk.sv
module lau_align_chk
  import lau_pkg::*;
(
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  output logic [CNT_W-1:0] nbytes,
  output logic             mis
);
  always_comb begin
    case (size)
      SZ_BYTE: begin nbytes = CNT_W'(1); mis = 1'b0;            end
      SZ_HALF: begin nbytes = CNT_W'(2); mis = offset[0];       end
      default: begin nbytes = CNT_W'(4); mis = (offset != '0);  end
    endcase
  end
endmodule

// File: rtl/lau_seq.sv
module lau_seq
  import lau_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic two_reads,
  input  logic mem_ready,
  input  logic mem_rvalid,
  output logic req_ready,
  output logic mem_req,
  output logic done,
  output logic phase,
  output logic cap0,
  output logic cap1
);
  state_e state_q, state_d;
  logic   phase_q, phase_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    case (state_q)
      ST_IDLE:  if (req_valid) begin state_d = ST_ISSUE; phase_d = 1'b0; end
      ST_ISSUE: if (mem_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rvalid) begin
                  if (!phase_q && two_reads) begin
                    state_d = ST_ISSUE;
                    phase_d = 1'b1;
                  end else begin
                    state_d = ST_DONE;
                  end
                end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_ISSUE);
  assign done      = (state_q == ST_DONE);
  assign phase     = phase_q;
  assign cap0      = (state_q == ST_WAIT) && mem_rvalid && !phase_q;
  assign cap1      = (state_q == ST_WAIT) && mem_rvalid &&  phase_q;
endmodule

// File: rtl/lau_merge.sv
module lau_merge
  import lau_pkg::*;
(
  input  logic [WORD_W-1:0] word_lo,
  input  logic [WORD_W-1:0] word_hi,
  input  logic [OFF_W-1:0]  offset,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              big,
  output logic [WORD_W-1:0] res
);
  localparam int PAIR_W = 2 * WORD_W;
  localparam int IDX_W  = OFF_W + 1;

  logic [PAIR_W-1:0] pair;
  logic [7:0]        item_b [WORD_BYTES];

  assign pair = {word_hi, word_lo};

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_pick
    logic [IDX_W-1:0] idx;
    assign idx       = {1'b0, offset} + IDX_W'(g);
    assign item_b[g] = pair[{idx, 3'b000} +: 8];
  end

  always_comb begin
    res = '0;
    for (int k = 0; k < WORD_BYTES; k++) begin
      logic [OFF_W-1:0] sel;
      sel = big ? OFF_W'(nbytes - CNT_W'(1) - CNT_W'(k)) : OFF_W'(k);
      if (CNT_W'(k) < nbytes) res[8*k +: 8] = item_b[sel];
    end
  end
endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import lau_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_big_endian,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic              misaligned,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int WADDR_W = ADDR_W - OFF_W;

  logic [WADDR_W-1:0] wbase_q;
  logic [OFF_W-1:0]   off_q;
  logic [CNT_W-1:0]   nbytes_q, nbytes_d;
  logic               big_q, mis_q, mis_d;
  logic [WORD_W-1:0]  w0_q, w1_q;
  logic               phase, cap0, cap1, fire;

  lau_align_chk u_chk (
    .offset (req_addr[OFF_W-1:0]),
    .size   (req_size),
    .nbytes (nbytes_d),
    .mis    (mis_d)
  );

  lau_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .two_reads  (mis_q),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .done       (done),
    .phase      (phase),
    .cap0       (cap0),
    .cap1       (cap1)
  );

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbase_q  <= '0;
      off_q    <= '0;
      nbytes_q <= CNT_W'(1);
      big_q    <= 1'b0;
      mis_q    <= 1'b0;
    end else if (fire) begin
      wbase_q  <= req_addr[ADDR_W-1:OFF_W];
      off_q    <= req_addr[OFF_W-1:0];
      nbytes_q <= nbytes_d;
      big_q    <= req_big_endian;
      mis_q    <= mis_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w0_q <= '0;
      w1_q <= '0;
    end else begin
      if (cap0) w0_q <= mem_rdata;
      if (cap1) w1_q <= mem_rdata;
    end
  end

  assign mem_addr   = wbase_q + WADDR_W'(phase);
  assign misaligned = mis_q;

  lau_merge u_merge (
    .word_lo (w0_q),
    .word_hi (w1_q),
    .offset  (off_q),
    .nbytes  (nbytes_q),
    .big     (big_q),
    .res     (result)
  );
endmodule

// File: rtl/lau_checker.sv
module lau_checker #(
  parameter int WADDR_W = 30
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               done,
  input logic               misaligned,
  input logic               mem_req,
  input logic               mem_ready,
  input logic [WADDR_W-1:0] mem_addr
);
  logic [1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          rd_cnt <= '0;
    else if (req_valid && req_ready)  rd_cnt <= '0;
    else if (mem_req && mem_ready)    rd_cnt <= rd_cnt + 2'd1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_req && !done));

  assert_flag_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> $stable(misaligned));

  assert_read_count_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_cnt == (misaligned ? 2'd2 : 2'd1)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_ready);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
endmodule

bind load_align_unit lau_checker #(.WADDR_W(ADDR_W - lau_pkg::OFF_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .misaligned (misaligned),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr)
);

// File: tb/load_align_unit_tb_top.sv
`timescale 1ns/1ps
module load_align_unit_tb_top;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]  req_size = 2'b00;
  logic        req_big_endian = 1'b0;
  logic        done;
  logic [31:0] result;
  logic        misaligned;
  logic        mem_req;
  logic        mem_ready;
  logic [AW-3:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  load_align_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_big_endian(req_big_endian),
    .done(done), .result(result), .misaligned(misaligned),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [16];
  logic        stall_en = 1'b0;
  int          rd_lat = 0;
  logic        tick = 1'b0;
  int          pend = 0;
  logic [3:0]  pend_addr = '0;
  int          rd_total = 0;
  logic [3:0]  rd_log [256];
  int          checks = 0;
  int          fails = 0;

  assign mem_ready = stall_en ? tick : 1'b1;

  always @(posedge clk) begin
    tick       <= ~tick;
    mem_rvalid <= 1'b0;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[pend_addr];
      end
    end else if (mem_req && mem_ready) begin
      pend      <= rd_lat + 1;
      pend_addr <= mem_addr;
      rd_log[rd_total[7:0]] <= mem_addr;
      rd_total  <= rd_total + 1;
    end
  end

  function automatic logic [7:0] byte_at(input logic [AW-1:0] a);
    return mem[a[5:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] model(input logic [AW-1:0] a, input int n, input logic be);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ai = a + AW'(i);
      if (be) r[8*(n-1-i) +: 8] = byte_at(ai);
      else    r[8*i +: 8]       = byte_at(ai);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [1:0] sz, input logic be,
                         input bit flip, input string tag);
    int n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    logic expm = (sz == 2'b01) ? a[0] : (sz == 2'b00) ? 1'b0 : (a[1:0] != 2'b00);
    logic [31:0] expv = model(a, n, be);
    int start, w;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start = rd_total;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_big_endian = be;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) req_big_endian = ~be;
    check(misaligned == expm, {"R2 flag ", tag}, 32'(misaligned), 32'(expm));
    check(!req_ready, {"R8 busy ", tag}, 32'(req_ready), 32'd0);
    w = 0;
    while (!done && w < 300) begin @(negedge clk); w++; end
    check(done, {"R8 done seen ", tag}, 32'(done), 32'd1);
    check(result == expv, {(be ? "R7 " : "R6 "), (flip ? "R10 " : ""), tag}, result, expv);
    check(misaligned == expm, {"R2 flag at done ", tag}, 32'(misaligned), 32'(expm));
    check(rd_total - start == (expm ? 2 : 1), {(expm ? "R4" : "R3"), " read count ", tag},
          32'(rd_total - start), expm ? 32'd2 : 32'd1);
    check(rd_log[start[7:0]] == a[5:2], {"R3 first word ", tag},
          32'(rd_log[start[7:0]]), 32'(a[5:2]));
    if (expm)
      check(rd_log[8'(start + 1)] == 4'(a[5:2] + 4'd1), {"R4 second word ", tag},
            32'(rd_log[8'(start + 1)]), 32'(4'(a[5:2] + 4'd1)));
    @(negedge clk);
    check(!done, {"R8 single pulse ", tag}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready && !mem_req && !done && !misaligned, "R1 in reset",
          {28'd0, req_ready, mem_req, done, misaligned}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !mem_req && !done && !misaligned, "R1 after reset",
          {28'd0, req_ready, mem_req, done, misaligned}, 32'h8);
  endtask

  task automatic t_examples();
    do_load(6'd20, 2'b10, 1'b1, 1'b0, "R7 example");
    check(result == 32'h11223344, "R7 literal", result, 32'h11223344);
    do_load(6'd20, 2'b10, 1'b0, 1'b0, "R6 example");
    check(result == 32'h44332211, "R6 literal", result, 32'h44332211);
    do_load(6'd21, 2'b00, 1'b0, 1'b0, "R5 lane1 byte");
    check(result == 32'h00000022, "R5 lane", result, 32'h22);
  endtask

  task automatic t_sweep();
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++)
        for (int b = 0; b < 2; b++)
          do_load(AW'(8 + o), 2'(s), b[0], 1'b0, "sweep");
  endtask

  task automatic t_wrap();
    do_load(6'd63, 2'b10, 1'b1, 1'b0, "R4 wrap word");
    do_load(6'd63, 2'b01, 1'b0, 1'b0, "R4 wrap half");
  endtask

  task automatic t_stall();
    stall_en = 1'b1; rd_lat = 2;
    do_load(6'd30, 2'b10, 1'b0, 1'b0, "R9 stall word");
    do_load(6'd13, 2'b01, 1'b1, 1'b0, "R9 stall half");
    do_load(6'd36, 2'b10, 1'b1, 1'b0, "R9 stall aligned");
    stall_en = 1'b0; rd_lat = 0;
  endtask

  task automatic t_mode_change();
    do_load(6'd41, 2'b10, 1'b1, 1'b1, "R10 flip to le");
    do_load(6'd42, 2'b01, 1'b0, 1'b1, "R10 flip to be");
  endtask

  initial begin
    for (int w = 0; w < 16; w++)
      for (int j = 0; j < 4; j++)
        mem[w][8*j +: 8] = 8'((4*w + j) * 37 + 11);
    mem[5] = 32'h44332211;
    t_reset();
    t_examples();
    t_sweep();
    t_wrap();
    t_stall();
    t_mode_change();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end
endmodule